// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block decides, in the same cycle, whether the instruction in the decode stage of a five-stage in-order pipeline may advance. It compares the source registers that the decode-stage instruction actually reads against the destination registers of the instructions in the execute and memory stages. When an operand cannot be obtained in time, it freezes the program counter and the fetch/decode pipeline register and sends a bubble into the decode/execute register.

There are two kinds of stall. The first is the ordinary load-use case: a load in execute whose data arrives too late for the instruction that follows it. The second is for branches, which are compared in decode and so need their operands earlier. A branch stalls when a register-writing instruction in execute produces one of its operands. It also stalls when a load in the memory stage produces one of its operands. A branch that follows a load directly therefore waits two cycles: one while the load is in execute and one while it is in memory. Register 0 never causes a stall. The forwarding paths and the register file are outside this block.

Top module: `hzd_stall_ctl`

## Requirements
- R1: When the execute-stage instruction is a load (`ex_mem_read`=1) and its destination equals a used decode source (rs1 with `id_use_rs1`=1, or rs2 with `id_use_rs2`=1), the block stalls: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1.
- R2: `pc_we` and `ifid_we` always have the same value, and `idex_bubble` is always their inverse.
- R3: A destination register number of 0 never causes a stall, in any stage and for any instruction kind.
- R4: A source whose use flag is 0 is never compared, so a matching value on that source does not cause a stall.
- R5: A decode-stage branch (`id_is_branch`=1) stalls when a register-writing instruction in execute (`ex_reg_write`=1 or `ex_mem_read`=1) writes one of its used sources. A non-branch stalls only when that execute-stage instruction is a load.
- R6: A decode-stage branch stalls when the memory-stage instruction is a load (`mem_mem_read`=1) whose destination equals a used source. A non-branch does not stall for that case.
- R7: A branch that directly follows a load that writes one of its sources stalls in two consecutive cycles: first with the load in execute, then with the load in memory. It advances on the third cycle.
- R8: With no matching condition, the block does not stall: `pc_we`=1, `ifid_we`=1, `idex_bubble`=0.
- R9: A non-load result in the memory stage never stalls a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used by the embedded checks |
| rst_n | input | 1 | Active-low reset that disables the checks |
| id_rs1 | input | REG_AW | First source register of the decode-stage instruction |
| id_rs2 | input | REG_AW | Second source register of the decode-stage instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
The embedded properties check on every cycle that the three outputs agree with each other. They also check that each individual stall cause (load-use, branch after an execute-stage writer, branch after a memory-stage load) forces a stall. Finally, they check that a quiet pipeline, unused sources and register-0 destinations leave the front end running. Only the bench's scenarios show that a non-branch ignores a memory-stage load or an execute-stage ALU result. The same holds for the two-cycle wait of a branch behind a load as the load moves from execute into memory, since that depends on how the pipeline advances around the block.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int NUM_CAUSE = 3;

    typedef enum int {
        CAUSE_LOAD_USE = 0,
        CAUSE_BR_EX    = 1,
        CAUSE_BR_MEMLD = 2
    } hzd_cause_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } hzd_ctl_t;

endpackage

// File: rtl/hzd_dest_match.sv
module hzd_dest_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] dest,
    input  logic              dest_valid,
    input  logic [REG_AW-1:0] src_a,
    input  logic              use_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic              use_b,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic nonzero_d;
    logic hit_a_d;
    logic hit_b_d;

    always_comb begin
        nonzero_d = (dest != ZERO_REG);
        hit_a_d   = use_a && (src_a == dest);
        hit_b_d   = use_b && (src_b == dest);
        hit       = dest_valid && nonzero_d && (hit_a_d || hit_b_d);
    end
endmodule

// File: rtl/hzd_stall_merge.sv
module hzd_stall_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] cause,
    output logic         stall
);
    always_comb begin
        stall = |cause;
    end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              id_is_branch,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_mem_read,
    input  logic              ex_reg_write,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_mem_read,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Per-cause destination and qualifier
    logic [REG_AW-1:0] cause_dest  [NUM_CAUSE];
    logic [NUM_CAUSE-1:0] cause_en;
    logic [NUM_CAUSE-1:0] cause_hit;
    logic              stall;
    hzd_ctl_t          ctl_d;

    always_comb begin
        cause_dest[CAUSE_LOAD_USE] = ex_rd;
        cause_en[CAUSE_LOAD_USE]   = ex_mem_read;
        cause_dest[CAUSE_BR_EX]    = ex_rd;
        cause_en[CAUSE_BR_EX]      = id_is_branch && (ex_reg_write || ex_mem_read);
        cause_dest[CAUSE_BR_MEMLD] = mem_rd;
        cause_en[CAUSE_BR_MEMLD]   = id_is_branch && mem_mem_read;
    end

    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_match
        hzd_dest_match #(.REG_AW(REG_AW)) u_match (
            .dest       (cause_dest[g]),
            .dest_valid (cause_en[g]),
            .src_a      (id_rs1),
            .use_a      (id_use_rs1),
            .src_b      (id_rs2),
            .use_b      (id_use_rs2),
            .hit        (cause_hit[g])
        );
    end

    hzd_stall_merge #(.N(NUM_CAUSE)) u_merge (
        .cause (cause_hit),
        .stall (stall)
    );

    always_comb begin
        ctl_d.pc_we   = !stall;
        ctl_d.ifid_we = !stall;
        ctl_d.bubble  = stall;
        pc_we         = ctl_d.pc_we;
        ifid_we       = ctl_d.ifid_we;
        idex_bubble   = ctl_d.bubble;
    end

    // R1: load in execute feeding a used source stalls
    a_r1_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_rd != ZERO_REG &&
         ((id_use_rs1 && id_rs1 == ex_rd) || (id_use_rs2 && id_rs2 == ex_rd)))
        |-> (!pc_we && idex_bubble));

    // R2: outputs consistent with each other
    a_r2_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (idex_bubble == !ifid_we));

    // R3: register zero everywhere never stalls
    a_r3_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == ZERO_REG && mem_rd == ZERO_REG) |-> (pc_we && !idex_bubble));

    // R4: no sources used means no stall
    a_r4_no_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_use_rs1 && !id_use_rs2) |-> pc_we);

    // R5: branch behind any execute-stage writer stalls
    a_r5_branch_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && ex_reg_write && ex_rd != ZERO_REG &&
         id_use_rs1 && id_rs1 == ex_rd) |-> !ifid_we);

    // R6: branch behind a memory-stage load stalls
    a_r6_branch_memld: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && mem_mem_read && mem_rd != ZERO_REG &&
         id_use_rs2 && id_rs2 == mem_rd) |-> !ifid_we);

    // R8: nothing writing in execute and no memory load means no stall
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_mem_read && !ex_reg_write && !mem_mem_read) |-> (pc_we && !idex_bubble));

endmodule

// File: tb/hzd_stall_ctl_test.sv
module hzd_stall_ctl_test;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
    logic id_use_rs1 = 1'b0, id_use_rs2 = 1'b0, id_is_branch = 1'b0;
    logic ex_mem_read = 1'b0, ex_reg_write = 1'b0, mem_mem_read = 1'b0;
    logic pc_we, ifid_we, idex_bubble;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hzd_stall_ctl #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_is_branch(id_is_branch),
        .ex_rd(ex_rd), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
        .mem_rd(mem_rd), .mem_mem_read(mem_mem_read),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
    );

    typedef struct packed {
        logic [4:0] rs1; logic [4:0] rs2; logic u1; logic u2; logic br;
        logic [4:0] exrd; logic exmr; logic exrw;
        logic [4:0] memrd; logic memmr;
        logic stall; logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 5'd3, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 4'd8},   // R8
        '{5'd5, 5'd1, 1'b1, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 4'd1},   // R1
        '{5'd1, 5'd7, 1'b1, 1'b1, 1'b0, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 4'd1},   // R1
        '{5'd0, 5'd2, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 4'd3},   // R3
        '{5'd1, 5'd9, 1'b1, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 4'd4},   // R4
        '{5'd6, 5'd2, 1'b1, 1'b1, 1'b1, 5'd6, 1'b0, 1'b1, 5'd0, 1'b0, 1'b1, 4'd5},   // R5
        '{5'd6, 5'd2, 1'b1, 1'b1, 1'b0, 5'd6, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 4'd5},   // R5
        '{5'd1, 5'd10, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b1, 5'd10, 1'b1, 1'b1, 4'd6}, // R6
        '{5'd1, 5'd10, 1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 1'b1, 5'd10, 1'b1, 1'b0, 4'd6}, // R6
        '{5'd11, 5'd2, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b1, 5'd11, 1'b0, 1'b0, 4'd9}, // R9
        '{5'd0, 5'd0, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 4'd3},   // R3
        '{5'd12, 5'd2, 1'b1, 1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 4'd7}  // R7
    };

    task automatic check_out(input logic exp_stall, input string tag);
        checks++;
        if (pc_we !== !exp_stall || ifid_we !== !exp_stall || idex_bubble !== exp_stall) begin
            failures++;
            $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected pc_we=%b ifid_we=%b bubble=%b",
                     tag, pc_we, ifid_we, idex_bubble, !exp_stall, !exp_stall, exp_stall);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        id_rs1 = v.rs1; id_rs2 = v.rs2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
        id_is_branch = v.br; ex_rd = v.exrd; ex_mem_read = v.exmr;
        ex_reg_write = v.exrw; mem_rd = v.memrd; mem_mem_read = v.memmr;
        #1;
    endtask

    initial begin
        // Reset state: quiet pipeline, front end runs (R8, R2)
        repeat (2) @(negedge clk);
        #1;
        check_out(1'b0, "R8 reset quiet");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_out(VECS[i].stall, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R7: branch behind a load, cycle 1 load in execute
        apply('{5'd13, 5'd0, 1'b1, 1'b0, 1'b1, 5'd13, 1'b1, 1'b1, 5'd4, 1'b0, 1'b1, 4'd7});
        check_out(1'b1, "R7 cycle1 load in execute");
        // cycle 2: bubble in execute, load in memory
        apply('{5'd13, 5'd0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 5'd13, 1'b1, 1'b1, 4'd7});
        check_out(1'b1, "R7 cycle2 load in memory");
        // cycle 3: load retired, branch advances
        apply('{5'd13, 5'd0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd7});
        check_out(1'b0, "R7 cycle3 advance");

        // R4: rs1 unused but matches execute load, rs2 used and clear
        apply('{5'd14, 5'd3, 1'b0, 1'b1, 1'b0, 5'd14, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 4'd4});
        check_out(1'b0, "R4 unused rs1 ignored");
        // R2: enables follow bubble back after a stall
        apply('{5'd14, 5'd3, 1'b1, 1'b1, 1'b0, 5'd14, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 4'd2});
        check_out(1'b1, "R2 stalled outputs");
        // R3: branch with rs2=0 behind a memory load to register 0
        apply('{5'd5, 5'd0, 1'b0, 1'b1, 1'b1, 5'd1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 4'd3});
        check_out(1'b0, "R3 branch zero register");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule